// File: doc/BRIEF.md
# Serial-Bus Wiper Register Controller

This block is the digital front end of a digitally controlled potentiometer. It is an I2C target that holds the 7-bit volatile code selecting the wiper tap and passes that code to the analog tap decoder. SCL and SDA are sampled in the system clock domain, and START, repeated START and STOP are recognised there. A two-byte header selects the device: an identification byte carrying the 7-bit target address and the direction bit, followed by a register address byte. After the header the block either loads the wiper code or returns it.

The block pulls SDA low only through an open-drain enable. It never stretches the clock. The system clock must run at least eight times faster than SCL. After reset, a START is ignored until a power-up window has elapsed. The target address and the length of that window are parameters.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: After reset the wiper output is 40h and the SDA pull-down enable is 0.
- R2: A START seen within PWRUP_CYCLES clocks after reset is ignored. The identification byte that follows is not acknowledged and the wiper keeps its value.
- R3: An identification byte is the 7-bit SLAVE_ADDR in bits 7..1 and the direction in bit 0 (1 = read, 0 = write), sent MSB first. On a match the block drives SDA low for the ninth SCL clock. On a mismatch it gives no acknowledge and ignores every byte until the next START.
- R4: A write is START, identification byte with bit 0 = 0, address 00h, a data byte, then STOP. All three bytes are acknowledged, and the wiper takes the data byte's low 7 bits.
- R5: The wiper changes at the SCL falling edge that ends the data byte's last bit, before the acknowledge clock. It changes at no other time.
- R6: An address byte other than 00h is not acknowledged. The data byte that follows is neither acknowledged nor stored.
- R7: After an acknowledged identification byte with bit 0 = 1, the block sends {0, wiper} MSB first, with each bit stable while SCL is high. A read may follow a write header and a repeated START, or may come directly after START.
- R8: The block repeats the data byte for as long as the controller acknowledges on the ninth clock. After a non-acknowledge it releases SDA until the next START or STOP.
- R9: A STOP at any point returns the block to idle, and an unfinished data byte is discarded. A START in the middle of a byte restarts header reception.
- R10: The SDA pull-down enable changes only while SCL is low. It rises only at a detected SCL falling edge, and a STOP leaves it released.
- R11: A byte sent after the data byte of a write is not acknowledged and does not change the wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen at the pad |
| sda_i | input | 1 | Serial data as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| wiper_o | output | 7 | Wiper tap code to the analog decoder |

## Verification
The assertions check every cycle for properties that hold at all times. The wiper may change only after a detected SCL fall. The SDA pull-down stays steady while SCL is high, stays off before the power-up window closes, and is released after a STOP. Which bytes are acknowledged, which values reach the wiper, and what data is returned depend on whole bus transactions. Only the bench's scenarios can show these: valid and invalid headers, boundary codes, a continued read, and transfers cut short by STOP or START.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int BYTE_W  = 8;
  localparam int WIPER_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_WAIT
  } wdc_state_e;

  typedef enum logic [1:0] {
    PH_ID, PH_ADDR, PH_DATA
  } wdc_phase_e;

  function automatic logic id_hit(input logic [BYTE_W-1:0] b,
                                  input logic [WIPER_W-1:0] addr);
    return b[BYTE_W-1:1] == addr;
  endfunction

  function automatic logic byte_ok(input wdc_phase_e ph,
                                   input logic [BYTE_W-1:0] b,
                                   input logic [WIPER_W-1:0] addr);
    case (ph)
      PH_ID:   return id_hit(b, addr);
      PH_ADDR: return b == '0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [WIPER_W-1:0] byte_to_code(input logic [BYTE_W-1:0] b);
    return b[WIPER_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] code_to_byte(input logic [WIPER_W-1:0] c);
    return {{(BYTE_W-WIPER_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/wdc_bus_sync.sv
module wdc_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_ff[SYNC_STAGES-1];
  assign sda_s    = sda_ff[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/wdc_pwrup.sv
module wdc_pwrup #(
  parameter int PWRUP_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PWRUP_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LIMIT);
endmodule

// File: rtl/wdc_target_fsm.sv
module wdc_target_fsm
  import wdc_pkg::*;
#(
  parameter logic [WIPER_W-1:0] SLAVE_ADDR   = 7'h2E,
  parameter logic [WIPER_W-1:0] WIPER_PRESET = 7'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready,
  input  logic               ev_start,
  input  logic               ev_stop,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  output logic               sda_oe,
  output logic               wiper_we,
  output logic [WIPER_W-1:0] wiper
);
  localparam int BC_W = $clog2(BYTE_W + 1);
  localparam logic [BC_W-1:0] LAST = BC_W'(BYTE_W);

  wdc_state_e        state;
  wdc_phase_e        phase;
  logic [BC_W-1:0]   bcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              is_rd, mack;

  logic              byte_end;
  logic              accept;
  logic [BYTE_W-1:0] rd_byte;

  assign byte_end = (state == ST_RX) && scl_fall && (bcnt == LAST);
  assign accept   = byte_ok(phase, rx_sh, SLAVE_ADDR);
  assign wiper_we = byte_end && (phase == PH_DATA);
  assign rd_byte  = code_to_byte(wiper);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_ID;
      bcnt   <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      is_rd  <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      wiper  <= WIPER_PRESET;
    end else if (ev_stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (ev_start && ready) begin
      state  <= ST_RX;
      phase  <= PH_ID;
      bcnt   <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bcnt != LAST) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
            bcnt  <= bcnt + 1'b1;
          end else if (byte_end) begin
            if (accept) begin
              state  <= ST_ACK;
              sda_oe <= 1'b1;
            end else begin
              state  <= ST_WAIT;
            end
            if (phase == PH_ID) is_rd <= rx_sh[0];
            if (wiper_we) wiper <= byte_to_code(rx_sh);
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bcnt <= '0;
            case (phase)
              PH_ID: begin
                if (is_rd) begin
                  state  <= ST_TX;
                  tx_sh  <= rd_byte << 1;
                  sda_oe <= ~rd_byte[BYTE_W-1];
                  bcnt   <= BC_W'(1);
                end else begin
                  state  <= ST_RX;
                  phase  <= PH_ADDR;
                  sda_oe <= 1'b0;
                end
              end
              PH_ADDR: begin
                state  <= ST_RX;
                phase  <= PH_DATA;
                sda_oe <= 1'b0;
              end
              default: begin
                state  <= ST_WAIT;
                sda_oe <= 1'b0;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt == LAST) begin
              sda_oe <= 1'b0;
              state  <= ST_TXACK;
            end else begin
              sda_oe <= ~tx_sh[BYTE_W-1];
              tx_sh  <= tx_sh << 1;
              bcnt   <= bcnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              state  <= ST_TX;
              tx_sh  <= rd_byte << 1;
              sda_oe <= ~rd_byte[BYTE_W-1];
              bcnt   <= BC_W'(1);
            end else begin
              state  <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl
  import wdc_pkg::*;
#(
  parameter logic [WIPER_W-1:0] SLAVE_ADDR   = 7'h2E,
  parameter logic [WIPER_W-1:0] WIPER_PRESET = 7'h40,
  parameter int                 PWRUP_CYCLES = 64,
  parameter int                 SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic pwr_ready, wiper_we;

  wdc_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  wdc_pwrup #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .ready(pwr_ready)
  );

  wdc_target_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .WIPER_PRESET(WIPER_PRESET)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ready(pwr_ready),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .sda_oe(sda_oe_o), .wiper_we(wiper_we), .wiper(wiper_o)
  );
endmodule

// File: rtl/wdc_chk.sv
module wdc_chk
  import wdc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic               ev_stop,
  input logic               scl_s,
  input logic               scl_fall,
  input logic               sda_oe,
  input logic [WIPER_W-1:0] wiper
);
  // R5
  wiper_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper != $past(wiper)) |-> $past(scl_fall));

  // R10
  oe_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R10
  oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R2
  quiet_pwrup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !sda_oe);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);
endmodule

bind wiper_i2c_ctrl wdc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(pwr_ready), .ev_stop(ev_stop),
  .scl_s(scl_s), .scl_fall(scl_fall), .sda_oe(sda_oe_o), .wiper(wiper_o)
);

// File: tb/wiper_i2c_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_i2c_ctrl_bench;
  localparam int HALF = 10;
  localparam logic [6:0] ADDR = 7'h2E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [6:0] wiper;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [6:0] wiper_mid;

  always #2.5 clk = ~clk;

  wiper_i2c_ctrl u_wiper_i2c_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wiper_o(wiper)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1; scl_m = 1; waitc(HALF);
    sda_m = 0; waitc(HALF);
    scl_m = 0; waitc(2);
  endtask

  task automatic i2c_rstart();
    sda_m = 1; waitc(HALF);
    scl_m = 1; waitc(HALF);
    sda_m = 0; waitc(HALF);
    scl_m = 0; waitc(2);
  endtask

  task automatic i2c_stop();
    sda_m = 0; waitc(HALF);
    scl_m = 1; waitc(HALF);
    sda_m = 1; waitc(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      waitc(2);
      sda_m = b[i]; waitc(HALF);
      scl_m = 1; waitc(HALF);
      scl_m = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    waitc(HALF);
    @(negedge clk) wiper_mid = wiper;
    sda_m = 1; waitc(2);
    scl_m = 1; waitc(HALF / 2);
    @(negedge clk) ack = sda_line;
    waitc(HALF / 2);
    scl_m = 0; waitc(2);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitc(HALF);
      scl_m = 1; waitc(HALF / 2);
      @(negedge clk) b[i] = sda_line;
      waitc(HALF / 2);
      scl_m = 0;
    end
    waitc(2);
    sda_m = mack ? 1'b0 : 1'b1; waitc(HALF);
    scl_m = 1; waitc(HALF);
    scl_m = 0; waitc(2);
    sda_m = 1;
  endtask

  task automatic do_write(input logic [7:0] d, output logic a0, output logic a1, output logic a2);
    i2c_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h00, a1);
    send_byte(d, a2);
    i2c_stop();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(wiper == 7'h40, "R1 wiper preset", wiper, 7'h40);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
  endtask

  task automatic t_pwrup();
    logic a;
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    chk(a == 1'b1, "R2 early START not acked", a, 1);
    i2c_stop();
    chk(wiper == 7'h40, "R2 wiper kept", wiper, 7'h40);
    waitc(100);
  endtask

  task automatic t_write();
    logic a0, a1, a2;
    i2c_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h00, a1);
    chk(wiper == 7'h40, "R5 wiper before data", wiper, 7'h40);
    send_byte(8'hD5, a2);
    chk(wiper_mid == 7'h55, "R5 wiper updated before ack clock", wiper_mid, 7'h55);
    i2c_stop();
    chk({a0, a1, a2} == 3'b000, "R3 R4 three acks", {a0, a1, a2}, 0);
    chk(wiper == 7'h55, "R4 wiper low 7 bits", wiper, 7'h55);
  endtask

  task automatic t_read_cont();
    logic a0, a1, a2;
    logic [7:0] b0, b1;
    i2c_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h00, a1);
    i2c_rstart();
    send_byte({ADDR, 1'b1}, a2);
    chk({a0, a1, a2} == 3'b000, "R7 header acks", {a0, a1, a2}, 0);
    recv_byte(1'b1, b0);
    chk(b0 == 8'h55, "R7 read data", b0, 8'h55);
    recv_byte(1'b0, b1);
    chk(b1 == 8'h55, "R8 repeated byte after ack", b1, 8'h55);
    waitc(HALF);
    @(negedge clk);
    chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic t_bad_addr();
    logic a0, a1, a2;
    i2c_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h01, a1);
    send_byte(8'h11, a2);
    i2c_stop();
    chk(a1 == 1'b1, "R6 nonzero address nacked", a1, 1);
    chk(a2 == 1'b1, "R6 data after bad address nacked", a2, 1);
    chk(wiper == 7'h55, "R6 wiper unchanged", wiper, 7'h55);
  endtask

  task automatic t_bad_id();
    logic a0, a1, a2;
    i2c_start();
    send_byte({7'h3E, 1'b0}, a0);
    send_byte(8'h00, a1);
    send_byte(8'h22, a2);
    i2c_stop();
    chk(a0 == 1'b1, "R3 other address nacked", a0, 1);
    chk({a1, a2} == 2'b11, "R3 rest ignored", {a1, a2}, 3);
    chk(wiper == 7'h55, "R3 wiper unchanged", wiper, 7'h55);
  endtask

  task automatic t_abort_stop();
    logic a0, a1;
    i2c_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h00, a1);
    send_bits(8'h00, 4);
    waitc(2);
    i2c_stop();
    chk(wiper == 7'h55, "R9 partial data dropped on STOP", wiper, 7'h55);
  endtask

  task automatic t_abort_start();
    logic a0, a1, a2;
    i2c_start();
    send_bits({ADDR, 1'b0}, 3);
    waitc(2);
    i2c_rstart();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h00, a1);
    send_byte(8'h00, a2);
    i2c_stop();
    chk({a0, a1, a2} == 3'b000, "R9 restart acks", {a0, a1, a2}, 0);
    chk(wiper == 7'h00, "R9 write after mid-byte START", wiper, 0);
  endtask

  task automatic t_extra();
    logic a0, a1, a2, a3;
    i2c_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h00, a1);
    send_byte(8'h7F, a2);
    send_byte(8'h12, a3);
    i2c_stop();
    chk(a3 == 1'b1, "R11 extra byte nacked", a3, 1);
    chk(wiper == 7'h7F, "R11 wiper keeps first data", wiper, 7'h7F);
  endtask

  task automatic t_direct_read();
    logic a0;
    logic [7:0] b0;
    i2c_start();
    send_byte({ADDR, 1'b1}, a0);
    chk(a0 == 1'b0, "R7 direct read id acked", a0, 0);
    recv_byte(1'b0, b0);
    chk(b0 == 8'h7F, "R7 direct read value", b0, 8'h7F);
    i2c_stop();
  endtask

  initial begin
    waitc(5);
    t_reset();
    rst_n = 1;
    #1;
    t_pwrup();
    t_write();
    t_read_cont();
    t_bad_addr();
    t_bad_id();
    t_abort_stop();
    t_abort_start();
    t_extra();
    t_direct_read();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule